// File: doc/BRIEF.md
# Tagged Command Write Port

This block sits between a processor that writes commands into a small window of word addresses and a slower SIMD pixel-array controller that consumes them. Each accepted bus write is packed into one queue word: the 32 data bits with the 4 low address bits attached as a tag. The queue smooths out bursts from the processor. When the queue has no free entry, the port lowers its ready signal, and the writer holds its write until there is room.

On the consumer side, a decode stage pops one word per cycle while the consumer allows it. Words tagged as linear-expression coefficients only update the held A, B and C values. An opcode word issues a command: a one-cycle valid pulse that presents the opcode together with the coefficients currently held. A long opcode is written as a high word followed by a low word, and only the low word issues. All remaining tags go out on a separate control channel.

Top module: `cmd_fifo_port`

## Requirements
- R1: Words leave the queue in the order they were accepted, each keeping the tag it was written with (tag = wrAddr[3:0], payload = wrData).
- R2: When DEPTH words are held, wrReady is low. A write presented while wrReady is low is not stored, and no stored word is lost or overwritten.
- R3: A popped word with tag 0, 1 or 2 replaces the held A, B or C value respectively, shown on cmdA, cmdB and cmdC from the next cycle. It raises neither cmdValid nor ctrlValid.
- R4: A popped word with tag 3 (short opcode) raises cmdValid for exactly one cycle, with cmdWide = 0, cmdOpLo = its payload, and cmdA/cmdB/cmdC equal to the most recently loaded coefficients. The opcode works whether or not coefficients were written before it.
- R5: A popped word with tag 4 stores the high opcode half and issues nothing. A popped word with tag 5 raises cmdValid for one cycle with cmdWide = 1, cmdOpLo = its payload and cmdOpHi = the most recent tag-4 payload.
- R6: A popped word with a tag from 6 to 15 raises ctrlValid for one cycle with ctrlTag and ctrlData equal to the word. It never raises cmdValid.
- R7: While popEn is low, no word is consumed: cmdValid and ctrlValid stay low, and the held outputs do not change.
- R8: After reset the queue is empty, wrReady is 1, cmdValid and ctrlValid are 0, and A, B, C and both opcode halves read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 4 | Word offset within the window; becomes the tag |
| wrData | input | 32 | Write payload |
| wrReady | output | 1 | High when a write is accepted this cycle |
| popEn | input | 1 | Consumer allows one word to be decoded per cycle |
| cmdValid | output | 1 | One-cycle command issue pulse |
| cmdWide | output | 1 | Issued opcode is the two-word form |
| cmdOpHi | output | 32 | High opcode half |
| cmdOpLo | output | 32 | Opcode, or low half of a long opcode |
| cmdA | output | 32 | Held A coefficient |
| cmdB | output | 32 | Held B coefficient |
| cmdC | output | 32 | Held C coefficient |
| ctrlValid | output | 1 | One-cycle control-word pulse |
| ctrlTag | output | 4 | Tag of the control word |
| ctrlData | output | 32 | Payload of the control word |

## Verification
The bench builds the port with DEPTH = 4, so the queue fills after four writes. This brings the stalled-write path, the wrap of both pointers and the drain-to-empty order within a few dozen cycles. The rest of the widths stay at their defaults. The decode rules are walked one word at a time across every tag class, and then under back-pressure from popEn.

// File: rtl/cmd_fifo_pkg.sv
package cmd_fifo_pkg;
  localparam int TAG_W = 4;

  localparam logic [TAG_W-1:0] TAG_COEF_A = 4'd0;
  localparam logic [TAG_W-1:0] TAG_COEF_B = 4'd1;
  localparam logic [TAG_W-1:0] TAG_COEF_C = 4'd2;
  localparam logic [TAG_W-1:0] TAG_OP_SHORT = 4'd3;
  localparam logic [TAG_W-1:0] TAG_OP_HIGH = 4'd4;
  localparam logic [TAG_W-1:0] TAG_OP_LOW = 4'd5;

  typedef struct packed {
    logic push;
    logic pop;
    logic ldA;
    logic ldB;
    logic ldC;
    logic ldHi;
    logic issue;
    logic issueWide;
    logic ctrl;
  } fifoStb_t;
endpackage

// File: rtl/cmd_fifo_ctrl.sv
module cmd_fifo_ctrl
  import cmd_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             popEn,
  input  logic [TAG_W-1:0] headTag,
  output logic             wrReady,
  output logic [AW-1:0]    wrPtr,
  output logic [AW-1:0]    rdPtr,
  output logic [CW-1:0]    level,
  output fifoStb_t         stb
);
  logic full;
  logic empty;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign wrReady = !full;

  always_comb begin
    stb      = '0;
    stb.push = wrEn && !full;
    stb.pop  = popEn && !empty;
    if (stb.pop) begin
      unique case (headTag)
        TAG_COEF_A:   stb.ldA = 1'b1;
        TAG_COEF_B:   stb.ldB = 1'b1;
        TAG_COEF_C:   stb.ldC = 1'b1;
        TAG_OP_SHORT: stb.issue = 1'b1;
        TAG_OP_HIGH:  stb.ldHi = 1'b1;
        TAG_OP_LOW: begin
          stb.issue     = 1'b1;
          stb.issueWide = 1'b1;
        end
        default:      stb.ctrl = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + AW'(1);
      if (stb.pop)  rdPtr <= rdPtr + AW'(1);
      case ({stb.push, stb.pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cmd_fifo_dp.sv
module cmd_fifo_dp
  import cmd_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [AW-1:0]     wrPtr,
  input  logic [AW-1:0]     rdPtr,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  output logic [TAG_W-1:0]  headTag,
  output logic              cmdValid,
  output logic              cmdWide,
  output logic [DATA_W-1:0] cmdOpHi,
  output logic [DATA_W-1:0] cmdOpLo,
  output logic [DATA_W-1:0] cmdA,
  output logic [DATA_W-1:0] cmdB,
  output logic [DATA_W-1:0] cmdC,
  output logic              ctrlValid,
  output logic [TAG_W-1:0]  ctrlTag,
  output logic [DATA_W-1:0] ctrlData
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] head;
  logic [DATA_W-1:0] headData;

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= {wrTag, wrData};
  end

  assign head     = store[rdPtr];
  assign headTag  = head[WORD_W-1 -: TAG_W];
  assign headData = head[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdWide   <= 1'b0;
      cmdOpHi   <= '0;
      cmdOpLo   <= '0;
      cmdA      <= '0;
      cmdB      <= '0;
      cmdC      <= '0;
      ctrlValid <= 1'b0;
      ctrlTag   <= '0;
      ctrlData  <= '0;
    end else begin
      cmdValid  <= stb.issue;
      ctrlValid <= stb.ctrl;
      if (stb.ldA)  cmdA    <= headData;
      if (stb.ldB)  cmdB    <= headData;
      if (stb.ldC)  cmdC    <= headData;
      if (stb.ldHi) cmdOpHi <= headData;
      if (stb.issue) begin
        cmdOpLo <= headData;
        cmdWide <= stb.issueWide;
      end
      if (stb.ctrl) begin
        ctrlTag  <= headTag;
        ctrlData <= headData;
      end
    end
  end
endmodule

// File: rtl/cmd_fifo_port.sv
module cmd_fifo_port
  import cmd_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [TAG_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              popEn,
  output logic              cmdValid,
  output logic              cmdWide,
  output logic [DATA_W-1:0] cmdOpHi,
  output logic [DATA_W-1:0] cmdOpLo,
  output logic [DATA_W-1:0] cmdA,
  output logic [DATA_W-1:0] cmdB,
  output logic [DATA_W-1:0] cmdC,
  output logic              ctrlValid,
  output logic [TAG_W-1:0]  ctrlTag,
  output logic [DATA_W-1:0] ctrlData
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStb_t         stb;
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    level;
  logic [TAG_W-1:0] headTag;

  cmd_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .popEn(popEn), .headTag(headTag),
    .wrReady(wrReady), .wrPtr(wrPtr), .rdPtr(rdPtr), .level(level), .stb(stb)
  );

  cmd_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrTag(wrAddr), .wrData(wrData), .headTag(headTag),
    .cmdValid(cmdValid), .cmdWide(cmdWide), .cmdOpHi(cmdOpHi), .cmdOpLo(cmdOpLo),
    .cmdA(cmdA), .cmdB(cmdB), .cmdC(cmdC),
    .ctrlValid(ctrlValid), .ctrlTag(ctrlTag), .ctrlData(ctrlData)
  );
endmodule

// File: rtl/cmd_fifo_port_chk.sv
module cmd_fifo_port_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrReady,
  input logic              popEn,
  input logic              cmdValid,
  input logic              ctrlValid,
  input logic [DATA_W-1:0] cmdA,
  input logic [CW-1:0]     level
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= CW'(DEPTH)) else $error("level above depth"); // R2
  AST_STALL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrReady) |=> (level <= $past(level))) else $error("stalled write stored"); // R2
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ctrlValid)) else $error("command and control together"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !popEn |=> (!cmdValid && !ctrlValid)) else $error("issue without pop"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !popEn |=> $stable(cmdA)) else $error("coefficient moved without pop"); // R7
  AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |=> !cmdValid) else $error("issue from empty queue"); // R4
endmodule

bind cmd_fifo_port cmd_fifo_port_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrReady(wrReady), .popEn(popEn),
  .cmdValid(cmdValid), .ctrlValid(ctrlValid), .cmdA(cmdA), .level(level)
);

// File: tb/cmd_fifo_port_bench.sv
module cmd_fifo_port_bench;
  localparam int DEPTH = 4;
  localparam int NV = 10;
  // vector: tag[37:34], data[33:2], expected kind[1:0] (0 none, 1 command, 2 control)
  localparam logic [37:0] VEC [NV] = '{
    {4'h0, 32'h11111111, 2'd0},
    {4'h1, 32'h22222222, 2'd0},
    {4'h2, 32'h33333333, 2'd0},
    {4'h3, 32'h0000ABCD, 2'd1},
    {4'h7, 32'hDEADBEEF, 2'd2},
    {4'h4, 32'hCAFE0001, 2'd0},
    {4'h5, 32'h0000F00D, 2'd1},
    {4'h0, 32'h44444444, 2'd0},
    {4'h3, 32'h00000077, 2'd1},
    {4'hF, 32'h12345678, 2'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic popEn = 1'b0;
  logic wrReady, cmdValid, cmdWide, ctrlValid;
  logic [31:0] cmdOpHi, cmdOpLo, cmdA, cmdB, cmdC, ctrlData;
  logic [3:0] ctrlTag;

  int nChk = 0;
  int nBad = 0;
  logic [31:0] mA = '0, mB = '0, mC = '0, mHi = '0;

  always #4 clk = ~clk;

  cmd_fifo_port #(.DATA_W(32), .DEPTH(DEPTH)) u_cmd_fifo_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .popEn(popEn), .cmdValid(cmdValid), .cmdWide(cmdWide),
    .cmdOpHi(cmdOpHi), .cmdOpLo(cmdOpLo), .cmdA(cmdA), .cmdB(cmdB), .cmdC(cmdC),
    .ctrlValid(ctrlValid), .ctrlTag(ctrlTag), .ctrlData(ctrlData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] t, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = t; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic popOne();
    @(negedge clk);
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 wrReady", 64'(wrReady), 64'd1);
    chk("R8 cmdValid", 64'(cmdValid), 64'd0);
    chk("R8 ctrlValid", 64'(ctrlValid), 64'd0);
    chk("R8 coefs", {cmdA, cmdB ^ cmdC}, 64'd0);
    chk("R8 opcode", {cmdOpHi, cmdOpLo}, 64'd0);

    // Vector walk: one word in, one word decoded, outputs compared
    for (int i = 0; i < NV; i++) begin
      logic [3:0] t;
      logic [31:0] d;
      logic [1:0] k;
      t = VEC[i][37:34]; d = VEC[i][33:2]; k = VEC[i][1:0];
      push(t, d);
      popOne();
      if (t == 4'd0) mA = d;
      if (t == 4'd1) mB = d;
      if (t == 4'd2) mC = d;
      if (t == 4'd4) mHi = d;
      chk("R1/R6 cmdValid", 64'(cmdValid), 64'(k == 2'd1));
      chk("R3/R6 ctrlValid", 64'(ctrlValid), 64'(k == 2'd2));
      chk("R3 held A", 64'(cmdA), 64'(mA));
      chk("R3 held B", 64'(cmdB), 64'(mB));
      chk("R3 held C", 64'(cmdC), 64'(mC));
      if (k == 2'd1) begin
        chk("R4 opLo", 64'(cmdOpLo), 64'(d));
        chk("R5 wide", 64'(cmdWide), 64'(t == 4'd5));
        if (t == 4'd5) chk("R5 opHi", 64'(cmdOpHi), 64'(mHi));
      end
      if (k == 2'd2) chk("R6 ctrl word", {28'd0, ctrlTag, ctrlData}, {28'd0, t, d});
      @(negedge clk);
      chk("R4 single-cycle cmd", 64'(cmdValid), 64'd0);
      chk("R6 single-cycle ctrl", 64'(ctrlValid), 64'd0);
    end

    // R7 words wait while popEn is low
    push(4'h3, 32'h00005555);
    repeat (3) @(negedge clk);
    chk("R7 no issue while held", 64'(cmdValid), 64'd0);
    chk("R7 opLo unchanged", 64'(cmdOpLo), 64'h77);
    popOne();
    chk("R7 issue after release", {31'd0, cmdValid, cmdOpLo}, {31'd0, 1'b1, 32'h5555});

    // R2 fill to depth, stalled write dropped from queue, R1 order kept
    for (int i = 0; i < DEPTH; i++) push(4'(8 + i), 32'hA000 + 32'(i));
    chk("R2 full", 64'(wrReady), 64'd0);
    push(4'h9, 32'hBADBAD00);
    chk("R2 still full", 64'(wrReady), 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      popOne();
      chk("R1 order tag", 64'(ctrlTag), 64'(8 + i));
      chk("R1 order data", 64'(ctrlData), 64'(32'hA000 + 32'(i)));
    end
    chk("R2 ready after drain", 64'(wrReady), 64'd1);
    popOne();
    chk("R2 stalled word absent", 64'(ctrlValid | cmdValid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule